// File: doc/BRIEF.md
# Date or Time Display View Selector

This block decides what an eight-digit BCD display shows: the calendar date or the time of day. Two user keys steer it. One key asks for the time, the other asks for the date. The chosen view is stored, so it stays in place after the key is let go.

If both keys are held at the same moment, the block treats that as no request and keeps the current view. The digit outputs follow the selected source inputs through combinational logic only, so a new date or time value reaches the display in the same cycle.

Segment decoding, display scanning and key debouncing are left to other blocks. The keys arrive already synchronised and free of bounce.

Top module: `view_select`

## Requirements
- R1: While `rst` is sampled high at a rising clock edge, the view becomes time view, so `view_time` reads 1 after that edge.
- R2: At a rising edge where `key_time` is 1 and `key_date` is 0, `view_time` becomes 1.
- R3: At a rising edge where `key_date` is 1 and `key_time` is 0, `view_time` becomes 0.
- R4: At a rising edge where both keys are 1, `view_time` keeps its value.
- R5: At a rising edge where neither key is 1, `view_time` keeps its value, so the view holds after the keys are released.
- R6: In date view (`view_time` = 0), the year's thousands, hundreds, tens and units digits appear on `dig0` to `dig3`, the month tens and units on `dig4` and `dig5`, and the day tens and units on `dig6` and `dig7`. The `date_bcd` input is packed as year thousands in [31:28], year hundreds in [27:24], year tens in [23:20], year units in [19:16], month tens in [15:12], month units in [11:8], day tens in [7:4] and day units in [3:0]. The digit outputs follow `date_bcd` in the same cycle.
- R7: In time view (`view_time` = 1), `dig0` and `dig1` both carry the blank code 4'hF. The hour tens and units appear on `dig2` and `dig3`, the minute tens and units on `dig4` and `dig5`, and the second tens and units on `dig6` and `dig7`. The `time_bcd` input is packed as hours in [23:16], minutes in [15:8] and seconds in [7:0], with the tens digit in the upper nibble of each byte. The digit outputs follow `time_bcd` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| key_time | input | 1 | Time-view key, active high, clean level |
| key_date | input | 1 | Date-view key, active high, clean level |
| date_bcd | input | 32 | Year, month and day as eight BCD digits |
| time_bcd | input | 24 | Hours, minutes and seconds as six BCD digits |
| dig0 | output | 4 | Leftmost display digit |
| dig1 | output | 4 | Display digit 1 |
| dig2 | output | 4 | Display digit 2 |
| dig3 | output | 4 | Display digit 3 |
| dig4 | output | 4 | Display digit 4 |
| dig5 | output | 4 | Display digit 5 |
| dig6 | output | 4 | Display digit 6 |
| dig7 | output | 4 | Rightmost display digit |
| view_time | output | 1 | 1 = time view, 0 = date view |

## Verification
The properties assume that both key inputs are already synchronous to `clk` and hold a stable level across each rising edge. They check the view only one edge after each key pattern is sampled. The bench changes keys and digit inputs only on falling edges. It holds `rst` high through the first rising edge, so every sampled key value is a defined 0 or 1. The digit inputs are not required to be valid BCD: the block passes them through unchanged, and the checks compare bit for bit.

// File: rtl/view_select.sv
module view_select #(
  parameter int DW = 4,
  parameter logic [DW-1:0] BLANK = '1
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            key_time,
  input  logic            key_date,
  input  logic [8*DW-1:0] date_bcd,
  input  logic [6*DW-1:0] time_bcd,
  output logic [DW-1:0]   dig0,
  output logic [DW-1:0]   dig1,
  output logic [DW-1:0]   dig2,
  output logic [DW-1:0]   dig3,
  output logic [DW-1:0]   dig4,
  output logic [DW-1:0]   dig5,
  output logic [DW-1:0]   dig6,
  output logic [DW-1:0]   dig7,
  output logic            view_time
);
  localparam int NDIG = 8;
  localparam int SW   = NDIG*DW;

  logic          view_q;
  logic [SW-1:0] shown;
  logic          one_key;

  assign one_key = key_time ^ key_date;

  always_ff @(posedge clk) begin
    if (rst)          view_q <= 1'b1;
    else if (one_key) view_q <= key_time;
  end

  assign view_time = view_q;
  assign shown = view_q ? {BLANK, BLANK, time_bcd} : date_bcd;

  assign dig0 = shown[8*DW-1 -: DW];
  assign dig1 = shown[7*DW-1 -: DW];
  assign dig2 = shown[6*DW-1 -: DW];
  assign dig3 = shown[5*DW-1 -: DW];
  assign dig4 = shown[4*DW-1 -: DW];
  assign dig5 = shown[3*DW-1 -: DW];
  assign dig6 = shown[2*DW-1 -: DW];
  assign dig7 = shown[DW-1:0];
endmodule

// File: rtl/view_select_chk.sv
module view_select_chk #(
  parameter int DW = 4
) (
  input logic            clk,
  input logic            rst,
  input logic            key_time,
  input logic            key_date,
  input logic [8*DW-1:0] date_bcd,
  input logic [6*DW-1:0] time_bcd,
  input logic [DW-1:0]   dig0,
  input logic [DW-1:0]   dig1,
  input logic [DW-1:0]   dig2,
  input logic [DW-1:0]   dig3,
  input logic [DW-1:0]   dig4,
  input logic [DW-1:0]   dig5,
  input logic [DW-1:0]   dig6,
  input logic [DW-1:0]   dig7,
  input logic            view_time
);
  a_r1_reset_time: assert property (@(posedge clk) rst |=> view_time);

  a_r2_time_key: assert property (@(posedge clk) disable iff (rst)
    (key_time && !key_date) |=> view_time);

  a_r3_date_key: assert property (@(posedge clk) disable iff (rst)
    (key_date && !key_time) |=> !view_time);

  a_r4_both_ignored: assert property (@(posedge clk) disable iff (rst)
    (key_time && key_date) |=> $stable(view_time));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!key_time && !key_date) |=> $stable(view_time));

  a_r6_date_digits: assert property (@(posedge clk) disable iff (rst)
    !view_time |-> ({dig0, dig1, dig2, dig3} == date_bcd[8*DW-1:4*DW]
                    && {dig4, dig5, dig6, dig7} == date_bcd[4*DW-1:0]));

  a_r7_time_digits: assert property (@(posedge clk) disable iff (rst)
    view_time |-> (&dig0 && &dig1
                   && {dig2, dig3, dig4, dig5, dig6, dig7} == time_bcd));
endmodule

bind view_select view_select_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_view_select.sv
module tb_view_select;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        key_time = 1'b0;
  logic        key_date = 1'b0;
  logic [31:0] date_bcd = 32'h2009_0531;
  logic [23:0] time_bcd = 24'h12_34_56;
  logic [3:0]  dig0, dig1, dig2, dig3, dig4, dig5, dig6, dig7;
  logic        view_time;
  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  view_select dut (
    .clk(clk), .rst(rst), .key_time(key_time), .key_date(key_date),
    .date_bcd(date_bcd), .time_bcd(time_bcd),
    .dig0(dig0), .dig1(dig1), .dig2(dig2), .dig3(dig3),
    .dig4(dig4), .dig5(dig5), .dig6(dig6), .dig7(dig7),
    .view_time(view_time)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] digits();
    return {dig0, dig1, dig2, dig3, dig4, dig5, dig6, dig7};
  endfunction

  task automatic edge_keys(input logic kt, input logic kd);
    @(negedge clk); key_time = kt; key_date = kd;
    @(posedge clk); #1;
    @(negedge clk); key_time = 1'b0; key_date = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    rst = 1'b1;
    @(posedge clk); #1;
    chk(view_time === 1'b1, "R1 reset view", {31'd0, view_time}, 32'd1);
    chk(digits() === {8'hFF, time_bcd}, "R7 digits after reset", digits(), {8'hFF, time_bcd});
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_date_key();
    edge_keys(1'b0, 1'b1);
    chk(view_time === 1'b0, "R3 date key", {31'd0, view_time}, 32'd0);
    chk(digits() === date_bcd, "R6 date digits", digits(), date_bcd);
  endtask

  task automatic t_time_key();
    edge_keys(1'b1, 1'b0);
    chk(view_time === 1'b1, "R2 time key", {31'd0, view_time}, 32'd1);
    chk(digits() === {8'hFF, time_bcd}, "R7 time digits", digits(), {8'hFF, time_bcd});
  endtask

  task automatic t_both(input logic expv);
    @(negedge clk); key_time = 1'b1; key_date = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    chk(view_time === expv, "R4 both keys ignored", {31'd0, view_time}, {31'd0, expv});
    @(negedge clk); key_time = 1'b0; key_date = 1'b0;
  endtask

  task automatic t_hold(input logic expv);
    repeat (5) @(posedge clk);
    #1;
    chk(view_time === expv, "R5 hold after release", {31'd0, view_time}, {31'd0, expv});
  endtask

  task automatic t_date_patterns();
    logic [31:0] pats [3] = '{32'h1999_1231, 32'h2024_0229, 32'h0000_0101};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); date_bcd = pats[i]; #1;
      chk(digits() === pats[i], "R6 date pattern", digits(), pats[i]);
    end
  endtask

  task automatic t_time_patterns();
    logic [23:0] pats [3] = '{24'h23_59_59, 24'h00_00_00, 24'h09_05_07};
    for (int i = 0; i < 3; i++) begin
      @(negedge clk); time_bcd = pats[i]; #1;
      chk(digits() === {8'hFF, pats[i]}, "R7 time pattern", digits(), {8'hFF, pats[i]});
    end
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_hold(1'b1);
    t_both(1'b1);
    t_date_key();
    t_date_patterns();
    t_hold(1'b0);
    t_both(1'b0);
    t_time_key();
    t_time_patterns();
    t_hold(1'b1);
    t_date_key();
    t_reset();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule